// File: doc/BRIEF.md
# Firmware Hub Nibble-Bus Target

This block is the target side of a four-bit, frame-delimited firmware bus. A host frames each transfer by pulling a frame line low for one clock while it places a start code on the nibble lines. It then sends an ID nibble, a 28-bit address one nibble at a time with the most significant nibble first, and a size nibble. A write carries one data byte as a low nibble followed by a high nibble. After each direction change, the target runs a two-cycle turnaround. It then signals its progress with sync nibbles for a fixed number of wait states. On a read, the byte comes back as the low nibble and then the high nibble. A closing turnaround returns the bus to the host.

Toward the storage side, the block issues single-cycle byte requests on a plain synchronous port. Read data is due one cycle after the request. Two active-low protection inputs raise a write-inhibit flag and block write requests. Two active-low reset inputs each put the block back into its idle read state with the nibble lines released. A low frame line in the middle of a transfer aborts the transfer and releases the bus in the same cycle.

The sequencer states are IDLE, IDSEL, ADDR, SIZE, WDLO, WDHI, TAR1, TAR2, SYNC, RDLO, RDHI, ETAR1 and ETAR2. The transitions are as follows.

- IDLE goes to IDSEL on a valid start.
- IDSEL goes to ADDR on an ID match. On a mismatch it returns to IDLE.
- ADDR goes to SIZE after seven nibbles.
- SIZE goes to WDLO for a write or TAR1 for a read, but only when the size nibble is zero. Otherwise it returns to IDLE.
- WDLO goes to WDHI, then to TAR1.
- TAR1 goes to TAR2, then to SYNC.
- SYNC goes to RDLO for a read or ETAR1 for a write once the wait states have elapsed.
- RDLO goes to RDHI, then to ETAR1.
- ETAR1 goes to ETAR2, then to IDLE.
- Any state other than IDLE goes to IDLE on an abort.

Top module: `nhub_target`

## Requirements
- R1: A transfer starts only when frame_n is low at a rising edge and bus_in holds 4'b1101 (read) or 4'b1110 (write) in that cycle. Any other start value, or a start code seen while frame_n is high, leaves the target idle with bus_oe low and no request issued.
- R2: The nibble after the start is compared with id_strap. On a mismatch the transfer is not claimed: bus_oe stays low and no request is issued.
- R3: Seven address nibbles follow the ID, most significant first. They form be_addr. The next nibble must be 4'b0000, or the transfer is not claimed.
- R4: Each turnaround lasts two cycles. The target drives 4'b1111 in the first cycle and floats in the second.
- R5: After the first turnaround, the target drives 4'b0101 for WAIT_STATES cycles and then 4'b0000 for one cycle.
- R6: On a read, be_req is high with be_we low in the first turnaround cycle. be_rdata is taken one cycle later. After the ready sync the target drives data bits 3..0 and then bits 7..4.
- R7: On a write, the host's low data nibble and then its high data nibble form be_wdata. be_req is high with be_we high for exactly one cycle, in the first turnaround cycle after the high nibble.
- R8: frame_n low while a transfer is in progress forces bus_oe low in that same cycle. The target then returns to idle.
- R9: An abort that arrives once the high write nibble has been taken does not cancel the write request. An abort at or before the high nibble cancels it.
- R10: While frame_n is high and no transfer is running, bus_oe is low.
- R11: While rst_bus_n or rst_cpu_n is low, bus_oe and be_req are low. A transfer in progress is dropped, and the target restarts in the idle read state.
- R12: When top_lock_n or wr_prot_n is low, be_wr_inhibit is high and write requests are suppressed. Reads are unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_bus_n | input | 1 | Interface reset, active low |
| rst_cpu_n | input | 1 | Processor reset, active low |
| frame_n | input | 1 | Frame line, low marks a start or an abort |
| bus_in | input | 4 | Nibble lines as seen from the bus |
| bus_out | output | 4 | Nibble value driven by the target |
| bus_oe | output | 1 | Output enable for bus_out |
| id_strap | input | 4 | ID that this target answers to |
| top_lock_n | input | 1 | Top block lock, active low |
| wr_prot_n | input | 1 | Write protect, active low |
| be_req | output | 1 | Storage request strobe |
| be_we | output | 1 | Request is a write |
| be_addr | output | 28 | Request byte address |
| be_wdata | output | 8 | Write byte |
| be_rdata | input | 8 | Read byte, valid the cycle after be_req |
| be_wr_inhibit | output | 1 | Writes forced off by the protection inputs |

## Verification
Cycle 0 is the start cycle. For a read, be_req appears in cycle 10, the turnaround drives 4'hF in cycle 10 and floats in cycle 11, and sync runs from cycle 12 to cycle 12+WAIT_STATES. The data nibbles follow at 13+W and 14+W, and the closing turnaround at 15+W and 16+W. A write shifts the first half of this schedule by two cycles: be_req in cycle 12 and the same closing cycles. Aborts and resets take effect on bus_oe in the cycle they are applied. The bench drives each nibble just after the falling edge and samples outputs 1 ns later within the same cycle. A monitor compares each be_req against the queue of expected requests in the cycle it appears.

// File: rtl/nhub_pkg.sv
package nhub_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_IDSEL, ST_ADDR, ST_SIZE,
        ST_WDLO, ST_WDHI, ST_TAR1, ST_TAR2,
        ST_SYNC, ST_RDLO, ST_RDHI, ST_ETAR1, ST_ETAR2
    } nhub_state_e;

    localparam logic [3:0] START_READ  = 4'b1101;
    localparam logic [3:0] START_WRITE = 4'b1110;
    localparam logic [3:0] SIZE_BYTE   = 4'b0000;
    localparam logic [3:0] SYNC_WAIT   = 4'b0101;
    localparam logic [3:0] SYNC_READY  = 4'b0000;
    localparam logic [3:0] TAR_DRIVE   = 4'b1111;

endpackage

// File: rtl/nhub_seq.sv
module nhub_seq
    import nhub_pkg::*;
#(
    parameter int ADDR_NIBBLES = 7,
    parameter int WAIT_STATES  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_n,
    input  logic [3:0]  bus_in,
    input  logic [3:0]  id_strap,
    output nhub_state_e state,
    output logic        is_wr,
    output logic        sync_ready
);
    localparam int CNT_TOP = (ADDR_NIBBLES > WAIT_STATES + 1) ? ADDR_NIBBLES : WAIT_STATES + 1;
    localparam int CW      = $clog2(CNT_TOP + 1);
    localparam logic [CW-1:0] ADDR_LAST = CW'(ADDR_NIBBLES - 1);
    localparam logic [CW-1:0] WAIT_LAST = CW'(WAIT_STATES);

    nhub_state_e   state_n;
    logic [CW-1:0] cnt_q;
    logic          start_hit;

    assign start_hit  = !frame_n && (bus_in == START_READ || bus_in == START_WRITE);
    assign sync_ready = (state == ST_SYNC) && (cnt_q == WAIT_LAST);

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:  state_n = start_hit ? ST_IDSEL : ST_IDLE;
            ST_IDSEL: state_n = (bus_in == id_strap) ? ST_ADDR : ST_IDLE;
            ST_ADDR:  state_n = (cnt_q == ADDR_LAST) ? ST_SIZE : ST_ADDR;
            ST_SIZE:  state_n = (bus_in != SIZE_BYTE) ? ST_IDLE : (is_wr ? ST_WDLO : ST_TAR1);
            ST_WDLO:  state_n = ST_WDHI;
            ST_WDHI:  state_n = ST_TAR1;
            ST_TAR1:  state_n = ST_TAR2;
            ST_TAR2:  state_n = ST_SYNC;
            ST_SYNC:  state_n = (cnt_q == WAIT_LAST) ? (is_wr ? ST_ETAR1 : ST_RDLO) : ST_SYNC;
            ST_RDLO:  state_n = ST_RDHI;
            ST_RDHI:  state_n = ST_ETAR1;
            ST_ETAR1: state_n = ST_ETAR2;
            ST_ETAR2: state_n = ST_IDLE;
            default:  state_n = ST_IDLE;
        endcase
        if (!frame_n && state != ST_IDLE) begin
            state_n = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt_q <= '0;
            is_wr <= 1'b0;
        end else begin
            state <= state_n;
            cnt_q <= (state_n != state) ? '0 : cnt_q + 1'b1;
            if (state == ST_IDLE && start_hit) begin
                is_wr <= (bus_in == START_WRITE);
            end
        end
    end

endmodule

// File: rtl/nhub_capture.sv
module nhub_capture
    import nhub_pkg::*;
#(
    parameter int ADDR_NIBBLES = 7,
    localparam int ADDR_W      = 4 * ADDR_NIBBLES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  nhub_state_e       state,
    input  logic [3:0]        bus_in,
    input  logic [7:0]        be_rdata,
    output logic [ADDR_W-1:0] addr_q,
    output logic [7:0]        wdata_q,
    output logic [7:0]        rdata_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            unique case (state)
                ST_ADDR: addr_q       <= {addr_q[ADDR_W-5:0], bus_in};
                ST_WDLO: wdata_q[3:0] <= bus_in;
                ST_WDHI: wdata_q[7:4] <= bus_in;
                ST_TAR2: rdata_q      <= be_rdata;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/nhub_target.sv
module nhub_target
    import nhub_pkg::*;
#(
    parameter int ADDR_NIBBLES = 7,
    parameter int WAIT_STATES  = 2,
    localparam int ADDR_W      = 4 * ADDR_NIBBLES
) (
    input  logic              clk,
    input  logic              rst_bus_n,
    input  logic              rst_cpu_n,
    input  logic              frame_n,
    input  logic [3:0]        bus_in,
    output logic [3:0]        bus_out,
    output logic              bus_oe,
    input  logic [3:0]        id_strap,
    input  logic              top_lock_n,
    input  logic              wr_prot_n,
    output logic              be_req,
    output logic              be_we,
    output logic [ADDR_W-1:0] be_addr,
    output logic [7:0]        be_wdata,
    input  logic [7:0]        be_rdata,
    output logic              be_wr_inhibit
);
    logic        rst_n;
    nhub_state_e state;
    logic        is_wr;
    logic        sync_ready;
    logic [7:0]  rdata_q;
    logic        drive;
    logic        protect;

    assign rst_n   = rst_bus_n & rst_cpu_n;
    assign protect = !top_lock_n || !wr_prot_n;

    nhub_seq #(
        .ADDR_NIBBLES (ADDR_NIBBLES),
        .WAIT_STATES  (WAIT_STATES)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_n    (frame_n),
        .bus_in     (bus_in),
        .id_strap   (id_strap),
        .state      (state),
        .is_wr      (is_wr),
        .sync_ready (sync_ready)
    );

    nhub_capture #(
        .ADDR_NIBBLES (ADDR_NIBBLES)
    ) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .bus_in   (bus_in),
        .be_rdata (be_rdata),
        .addr_q   (be_addr),
        .wdata_q  (be_wdata),
        .rdata_q  (rdata_q)
    );

    always_comb begin
        drive   = 1'b0;
        bus_out = 4'b0000;
        unique case (state)
            ST_TAR1, ST_ETAR1: begin
                drive   = 1'b1;
                bus_out = TAR_DRIVE;
            end
            ST_SYNC: begin
                drive   = 1'b1;
                bus_out = sync_ready ? SYNC_READY : SYNC_WAIT;
            end
            ST_RDLO: begin
                drive   = 1'b1;
                bus_out = rdata_q[3:0];
            end
            ST_RDHI: begin
                drive   = 1'b1;
                bus_out = rdata_q[7:4];
            end
            default: ;
        endcase
    end

    assign bus_oe        = drive && frame_n;
    assign be_req        = (state == ST_TAR1) && (!is_wr || !protect);
    assign be_we         = is_wr;
    assign be_wr_inhibit = protect;

endmodule

// File: rtl/nhub_target_chk.sv
module nhub_target_chk (
    input logic       clk,
    input logic       rst_bus_n,
    input logic       rst_cpu_n,
    input logic       frame_n,
    input logic [3:0] bus_out,
    input logic       bus_oe,
    input logic       be_req,
    input logic       be_we,
    input logic       be_wr_inhibit
);
    logic rst_n;
    assign rst_n = rst_bus_n & rst_cpu_n;

    assert_abort_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |-> !bus_oe);

    assert_single_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        be_req |=> !be_req);

    assert_prot_blocks_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (be_req && be_we) |-> !be_wr_inhibit);

    assert_ready_then_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && bus_out == 4'b0000 && frame_n) |=> (bus_oe || !frame_n));

    assert_read_tar_float_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (be_req && !be_we) |=> !bus_oe);

    assert_reset_quiet_R11: assert property (@(posedge clk)
        (!rst_bus_n || !rst_cpu_n) |-> (!bus_oe && !be_req));

endmodule

bind nhub_target nhub_target_chk u_chk (
    .clk           (clk),
    .rst_bus_n     (rst_bus_n),
    .rst_cpu_n     (rst_cpu_n),
    .frame_n       (frame_n),
    .bus_out       (bus_out),
    .bus_oe        (bus_oe),
    .be_req        (be_req),
    .be_we         (be_we),
    .be_wr_inhibit (be_wr_inhibit)
);

// File: tb/nhub_target_bench.sv
module nhub_target_bench;
    localparam int AN = 7;
    localparam int W  = 2;
    localparam int AW = 4 * AN;

    logic          clk = 1'b0;
    logic          rst_bus_n = 1'b0, rst_cpu_n = 1'b0, frame_n = 1'b1;
    logic [3:0]    bus_in = 4'h0, id_strap = 4'h3;
    logic          top_lock_n = 1'b1, wr_prot_n = 1'b1;
    logic [3:0]    bus_out;
    logic          bus_oe, be_req, be_we, be_wr_inhibit;
    logic [AW-1:0] be_addr;
    logic [7:0]    be_wdata;
    logic [7:0]    be_rdata = 8'h00;

    int n_run = 0;
    int n_fail = 0;

    typedef struct packed {
        logic          we;
        logic [AW-1:0] addr;
        logic [7:0]    data;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    nhub_target #(.ADDR_NIBBLES(AN), .WAIT_STATES(W)) u_nhub_target (
        .clk(clk), .rst_bus_n(rst_bus_n), .rst_cpu_n(rst_cpu_n), .frame_n(frame_n),
        .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .id_strap(id_strap),
        .top_lock_n(top_lock_n), .wr_prot_n(wr_prot_n), .be_req(be_req), .be_we(be_we),
        .be_addr(be_addr), .be_wdata(be_wdata), .be_rdata(be_rdata),
        .be_wr_inhibit(be_wr_inhibit)
    );

    // storage stub: read byte valid the cycle after the request
    always @(posedge clk) begin
        if (be_req === 1'b1 && be_we === 1'b0) be_rdata <= be_addr[7:0] ^ 8'hA5;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic look(input string tag, input bit eoe, input logic [3:0] eout);
        chk(bus_oe === eoe, tag, 32'(bus_oe), 32'(eoe));
        if (eoe) chk(bus_out === eout, tag, 32'(bus_out), 32'(eout));
    endtask

    task automatic idle_cycles(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            frame_n = 1'b1;
            bus_in  = 4'hD;
            #1;
            look(tag, 1'b0, 4'h0);
        end
    endtask

    // kind: 0 none, 1 frame abort, 2 rst_bus_n, 3 rst_cpu_n
    task automatic xact(input bit wr, input logic [3:0] id, input logic [AW-1:0] a,
                        input logic [3:0] size, input logic [7:0] d,
                        input int kind, input int kill_at, input string tag);
        bit claimed, prot, eoe;
        logic [3:0] eout, n;
        logic [7:0] rd;
        claimed = (id == id_strap) && (size == 4'h0);
        prot    = !top_lock_n || !wr_prot_n;
        rd      = a[7:0] ^ 8'hA5;
        if (claimed && !wr && (kind == 0 || kill_at >= 11)) exp_q.push_back('{1'b0, a, 8'h00});
        if (claimed && wr && !prot && (kind == 0 || kill_at >= 12)) exp_q.push_back('{1'b1, a, d});
        for (int i = 0; i < 17 + W; i++) begin
            @(negedge clk);
            n = 4'hF;
            if (i == 0) n = wr ? 4'hE : 4'hD;
            else if (i == 1) n = id;
            else if (i <= 1 + AN) n = a[AW-1-4*(i-2) -: 4];
            else if (i == 2 + AN) n = size;
            else if (wr && i == 10) n = d[3:0];
            else if (wr && i == 11) n = d[7:4];
            frame_n = (i == 0) ? 1'b0 : 1'b1;
            eoe = 1'b0;
            eout = 4'h0;
            if (claimed) begin
                if (wr) begin
                    if (i == 12 || i == 15 + W) begin eoe = 1; eout = 4'hF; end
                    else if (i >= 14 && i < 14 + W) begin eoe = 1; eout = 4'h5; end
                    else if (i == 14 + W) begin eoe = 1; eout = 4'h0; end
                end else begin
                    if (i == 10 || i == 15 + W) begin eoe = 1; eout = 4'hF; end
                    else if (i >= 12 && i < 12 + W) begin eoe = 1; eout = 4'h5; end
                    else if (i == 12 + W) begin eoe = 1; eout = 4'h0; end
                    else if (i == 13 + W) begin eoe = 1; eout = rd[3:0]; end
                    else if (i == 14 + W) begin eoe = 1; eout = rd[7:4]; end
                end
            end
            if (kind != 0 && i == kill_at) begin
                eoe = 1'b0;
                if (kind == 1) begin frame_n = 1'b0; n = 4'h0; end
                else if (kind == 2) rst_bus_n = 1'b0;
                else rst_cpu_n = 1'b0;
            end
            bus_in = n;
            #1;
            look(tag, eoe, eout);
            if (kind != 0 && i == kill_at) break;
        end
        @(negedge clk);
        rst_bus_n = 1'b1;
        rst_cpu_n = 1'b1;
        frame_n   = 1'b1;
        bus_in    = 4'hF;
        #1;
        look(tag, 1'b0, 4'h0);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (be_req === 1'b1) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R7/R6 unexpected request", 32'(be_addr), 32'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(be_we === e.we, e.we ? "R7 be_we" : "R6 be_we", 32'(be_we), 32'(e.we));
                    chk(be_addr === e.addr, "R3 be_addr", 32'(be_addr), 32'(e.addr));
                    if (e.we) chk(be_wdata === e.data, "R7 be_wdata", 32'(be_wdata), 32'(e.data));
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        chk(1'b0, "watchdog", 32'h0, 32'h1);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // R11: reset state
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            #1;
            chk(bus_oe === 1'b0, "R11 reset bus_oe", 32'(bus_oe), 32'h0);
            chk(be_req === 1'b0, "R11 reset be_req", 32'(be_req), 32'h0);
        end
        @(negedge clk);
        rst_bus_n = 1'b1;
        rst_cpu_n = 1'b1;
        idle_cycles(3, "R10 standby");

        // R1: unknown start code and a start code with frame high
        @(negedge clk);
        frame_n = 1'b0;
        bus_in  = 4'h9;
        #1;
        look("R1 bad start", 1'b0, 4'h0);
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            frame_n = 1'b1;
            bus_in  = (i == 0) ? id_strap : 4'h0;
            #1;
            look("R1 ignored frame", 1'b0, 4'h0);
        end

        xact(1'b0, 4'h3, 28'h0ABCDEF, 4'h0, 8'h00, 0, 0, "R6 read");
        xact(1'b1, 4'h3, 28'h1234567, 4'h0, 8'h3C, 0, 0, "R7 write");
        xact(1'b0, 4'h3, 28'hFEDCB98, 4'h0, 8'h00, 0, 0, "R6 read2");
        xact(1'b0, 4'h7, 28'h0000011, 4'h0, 8'h00, 0, 0, "R2 id mismatch");
        xact(1'b1, 4'h3, 28'h0000022, 4'h1, 8'h77, 0, 0, "R3 bad size");
        xact(1'b0, 4'h3, 28'h0000033, 4'h0, 8'h00, 1, 5, "R8 abort in address");
        xact(1'b0, 4'h3, 28'h0000044, 4'h0, 8'h00, 1, 13, "R8 abort in sync");
        xact(1'b1, 4'h3, 28'h0000055, 4'h0, 8'h99, 1, 11, "R9 abort on high nibble");
        xact(1'b1, 4'h3, 28'h0000066, 4'h0, 8'hA1, 1, 14, "R9 abort after data");
        xact(1'b0, 4'h3, 28'h0000077, 4'h0, 8'h00, 2, 4, "R11 bus reset");
        xact(1'b0, 4'h3, 28'h0000088, 4'h0, 8'h00, 3, 13, "R11 cpu reset");
        xact(1'b1, 4'h3, 28'h0000099, 4'h0, 8'h5E, 0, 0, "R11 after reset write");

        // R12: protection
        @(negedge clk);
        top_lock_n = 1'b0;
        #1;
        chk(be_wr_inhibit === 1'b1, "R12 inhibit top lock", 32'(be_wr_inhibit), 32'h1);
        xact(1'b1, 4'h3, 28'h00000AA, 4'h0, 8'h11, 0, 0, "R12 write locked");
        @(negedge clk);
        top_lock_n = 1'b1;
        wr_prot_n  = 1'b0;
        #1;
        chk(be_wr_inhibit === 1'b1, "R12 inhibit wp", 32'(be_wr_inhibit), 32'h1);
        xact(1'b0, 4'h3, 28'h00000BB, 4'h0, 8'h00, 0, 0, "R12 read protected");
        xact(1'b1, 4'h3, 28'h00000CC, 4'h0, 8'h22, 0, 0, "R12 write protected");
        @(negedge clk);
        wr_prot_n = 1'b1;
        #1;
        chk(be_wr_inhibit === 1'b0, "R12 inhibit clear", 32'(be_wr_inhibit), 32'h0);
        xact(1'b1, 4'h3, 28'h00000DD, 4'h0, 8'h33, 0, 0, "R12 write open");

        idle_cycles(4, "R10 standby end");
        chk(exp_q.size() == 0, "R7 pending requests", 32'(exp_q.size()), 32'h0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule